// File: doc/BRIEF.md
# Serial Controller Register Snooper

This block sits on the host I/O bus next to a dual-channel serial communications controller. It watches each host write to a channel's control port, follows the controller's indirect register pointer, and keeps a private copy of the few mode bits that matter to the board. The board is set up by the same writes that set up the controller. No separate configuration register exists.

From those copies it sets the direction of each channel's line-interface clock pin and frame-sync pin. It also steers the controller's two dual-role pins. The wait/request pin either stretches host data cycles through a bus-ready line or becomes a DMA request. The ready/request pin either drives the line-interface ready signal or becomes a DMA request. When it acts as a DMA request, the line-interface ready level is taken from a board register bit instead.

Top module: `sio_snoop`

## Requirements
- R1: After `rst` is high at a clock edge, every channel has `clk_drv`=0 and `frm_drv`=0, the wait/request pin is in wait role and the ready/request pin is in ready role. These defaults also hold after a later `rst`.
- R2: Per channel, a control write while the pointer is zero loads the pointer from `wr_data[3:0]`, and bits 7:4 are ignored. The next control write goes to the register that the pointer selects, and the pointer then returns to zero. Loading index 0 leaves the pointer at zero.
- R3: A write to register 11 sets the channel's `clk_drv` to bit 2 of the data, where 1 means output.
- R4: A write to register 4 captures data bits 5:2. `frm_drv` is 0 (input) when captured bits 3:2 are nonzero or captured bits 5:4 are 2'b11. Otherwise it is 1 (output).
- R5: A write to register 1 sets the wait/request pin role from data bit 6, where 1 means request. In request role `ctl_wq` of that channel drives its `dma_req`.
- R6: `bus_ready` is low only when some channel is in wait role with `ctl_wq` high, `card_wait_en` is high, `data_cyc` is high and `data_chan` selects that channel. A channel in request role never stretches.
- R7: A write to register 14 sets the ready/request pin role from data bit 2. In ready role (0), `line_rdy`=`ctl_rq` and the pin adds nothing to `dma_req`. In request role (1), `ctl_rq` drives `dma_req` and `line_rdy`=`card_rdy` of that channel.
- R8: Writes to one channel leave the other channel's pointer, copies and outputs unchanged, unless the command is the all-channel reset of R9.
- R9: A data write to register 9 with bit 7 set restores the writing channel to the defaults of R1 and clears its pointer. With bit 6 set, it does this for every channel.
- R10: Data writes to registers other than 1, 4, 9, 11 and 14 change no output.
- R11: A copied bit takes effect on the outputs in the cycle after the clock edge that captures the write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Host control-port write strobe, one cycle per write |
| wr_chan | input | CW | Channel addressed by the write |
| wr_data | input | 8 | Written byte |
| data_cyc | input | 1 | Host data-port read or write in progress |
| data_chan | input | CW | Channel addressed by the data cycle |
| ctl_wq | input | NCH | Controller wait/request pin level per channel (1 = active) |
| ctl_rq | input | NCH | Controller ready/request pin level per channel (1 = active) |
| card_wait_en | input | 1 | Board wait-state enable bit |
| card_rdy | input | NCH | Board-held line ready levels, used in request role |
| clk_drv | output | NCH | Line clock pin direction (1 = output) |
| frm_drv | output | NCH | Line frame-sync pin direction (1 = output) |
| line_rdy | output | NCH | Line-interface ready level |
| dma_req | output | NCH | DMA request per channel |
| bus_ready | output | 1 | Host bus ready; low stretches the data cycle |

## Verification
The bench builds the block with its default of two channels. It sweeps every register index from 1 to 15 with every byte value on both channels, so each mode field, each reset-command bit pattern and each ignored register is written exhaustively. After each write it drives all 32 combinations of pin levels, board bits and data-cycle flags on each channel. With two channels, the effect of one channel's writes on the other can be observed the whole time. Separate sequences cover pointer reload with index 0, the one-cycle capture latency, stretching requests aimed at the other channel, and a hardware reset in mid-run.

// File: rtl/sio_snoop_pkg.sv
package sio_snoop_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_PTR   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_ROLEW = 4'd1;
    localparam logic [IDX_W-1:0] IDX_MODE  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_CMD   = 4'd9;
    localparam logic [IDX_W-1:0] IDX_CLKSRC = 4'd11;
    localparam logic [IDX_W-1:0] IDX_AUX   = 4'd14;

    typedef struct packed {
        logic       clk_out;
        logic [3:0] mode;
        logic       wpin_req;
        logic       rpin_req;
    } shadow_t;

    localparam shadow_t SHADOW_RST = '{clk_out: 1'b0, mode: 4'b0001,
                                      wpin_req: 1'b0, rpin_req: 1'b0};

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } regwr_t;

    function automatic logic frame_is_input(input logic [3:0] m);
        return (m[1:0] != 2'b00) || (m[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/snoop_ptr.sv
module snoop_ptr
    import sio_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr,
    input  logic [BYTE_W-1:0] data,
    output regwr_t            rw
);
    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= IDX_PTR;
        end else if (wr) begin
            if (ptr == IDX_PTR) ptr <= data[IDX_W-1:0];
            else                ptr <= IDX_PTR;
        end
    end

    always_comb begin
        rw.valid = wr && (ptr != IDX_PTR);
        rw.idx   = ptr;
        rw.data  = data;
    end
endmodule

// File: rtl/snoop_shadow.sv
module snoop_shadow
    import sio_snoop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  regwr_t  rw,
    output shadow_t q
);
    logic unused_bits;
    assign unused_bits = ^{rw.data[7], rw.data[1:0]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= SHADOW_RST;
        end else if (rw.valid) begin
            case (rw.idx)
                IDX_ROLEW:  q.wpin_req <= rw.data[6];
                IDX_MODE:   q.mode     <= rw.data[5:2];
                IDX_CLKSRC: q.clk_out  <= rw.data[2];
                IDX_AUX:    q.rpin_req <= rw.data[2];
                default:    q          <= q;
            endcase
        end
    end
endmodule

// File: rtl/snoop_steer.sv
module snoop_steer
    import sio_snoop_pkg::*;
(
    input  shadow_t sh,
    input  logic    pin_wq,
    input  logic    pin_rq,
    input  logic    held_rdy,
    input  logic    wait_en,
    input  logic    cyc_here,
    output logic    clk_drv,
    output logic    frm_drv,
    output logic    line_rdy,
    output logic    dma_req,
    output logic    stretch
);
    always_comb begin
        clk_drv  = sh.clk_out;
        frm_drv  = !frame_is_input(sh.mode);
        line_rdy = sh.rpin_req ? held_rdy : pin_rq;
        dma_req  = (sh.wpin_req && pin_wq) || (sh.rpin_req && pin_rq);
        stretch  = !sh.wpin_req && wait_en && cyc_here && pin_wq;
    end
endmodule

// File: rtl/sio_snoop.sv
module sio_snoop
    import sio_snoop_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_chan,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              data_cyc,
    input  logic [CW-1:0]     data_chan,
    input  logic [NCH-1:0]    ctl_wq,
    input  logic [NCH-1:0]    ctl_rq,
    input  logic              card_wait_en,
    input  logic [NCH-1:0]    card_rdy,
    output logic [NCH-1:0]    clk_drv,
    output logic [NCH-1:0]    frm_drv,
    output logic [NCH-1:0]    line_rdy,
    output logic [NCH-1:0]    dma_req,
    output logic              bus_ready
);
    regwr_t           rw [NCH];
    shadow_t          sh [NCH];
    logic [NCH-1:0]   self_rst;
    logic [NCH-1:0]   all_rst;
    logic [NCH-1:0]   chan_clr;
    logic [NCH-1:0]   stretch;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_here;
        logic cyc_here;
        assign wr_here  = wr_en && (wr_chan == CW'(c));
        assign cyc_here = data_cyc && (data_chan == CW'(c));

        snoop_ptr u_ptr (
            .clk  (clk),
            .rst  (rst),
            .clr  (chan_clr[c]),
            .wr   (wr_here),
            .data (wr_data),
            .rw   (rw[c])
        );

        assign self_rst[c] = rw[c].valid && (rw[c].idx == IDX_CMD) && rw[c].data[7];
        assign all_rst[c]  = rw[c].valid && (rw[c].idx == IDX_CMD) && rw[c].data[6];
        assign chan_clr[c] = self_rst[c] || (|all_rst);

        snoop_shadow u_sh (
            .clk (clk),
            .rst (rst),
            .clr (chan_clr[c]),
            .rw  (rw[c]),
            .q   (sh[c])
        );

        snoop_steer u_st (
            .sh       (sh[c]),
            .pin_wq   (ctl_wq[c]),
            .pin_rq   (ctl_rq[c]),
            .held_rdy (card_rdy[c]),
            .wait_en  (card_wait_en),
            .cyc_here (cyc_here),
            .clk_drv  (clk_drv[c]),
            .frm_drv  (frm_drv[c]),
            .line_rdy (line_rdy[c]),
            .dma_req  (dma_req[c]),
            .stretch  (stretch[c])
        );
    end

    assign bus_ready = ~(|stretch);
endmodule

// File: rtl/sio_snoop_chk.sv
module sio_snoop_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic           data_cyc,
    input logic           card_wait_en,
    input logic [NCH-1:0] ctl_wq,
    input logic [NCH-1:0] ctl_rq,
    input logic [NCH-1:0] card_rdy,
    input logic [NCH-1:0] clk_drv,
    input logic [NCH-1:0] frm_drv,
    input logic [NCH-1:0] line_rdy,
    input logic [NCH-1:0] dma_req,
    input logic           bus_ready
);
    p_reset_dirs_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (clk_drv == '0) && (frm_drv == '0) && (dma_req == '0));

    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> ($stable(clk_drv) && $stable(frm_drv)));

    p_stretch_cause_r6: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> (data_cyc && card_wait_en));

    p_dma_source_r5: assert property (@(posedge clk) disable iff (rst)
        (dma_req & ~(ctl_wq | ctl_rq)) == '0);

    p_line_source_r7: assert property (@(posedge clk) disable iff (rst)
        ((line_rdy ^ ctl_rq) & (line_rdy ^ card_rdy)) == '0);
endmodule

bind sio_snoop sio_snoop_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .data_cyc     (data_cyc),
    .card_wait_en (card_wait_en),
    .ctl_wq       (ctl_wq),
    .ctl_rq       (ctl_rq),
    .card_rdy     (card_rdy),
    .clk_drv      (clk_drv),
    .frm_drv      (frm_drv),
    .line_rdy     (line_rdy),
    .dma_req      (dma_req),
    .bus_ready    (bus_ready)
);

// File: tb/sim_sio_snoop.sv
`timescale 1ns/100ps
module sim_sio_snoop;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [0:0]     wr_chan = '0;
    logic [7:0]     wr_data = '0;
    logic           data_cyc = 1'b0;
    logic [0:0]     data_chan = '0;
    logic [1:0]     ctl_wq = '0;
    logic [1:0]     ctl_rq = '0;
    logic           card_wait_en = 1'b0;
    logic [1:0]     card_rdy = '0;
    logic [1:0]     clk_drv, frm_drv, line_rdy, dma_req;
    logic           bus_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic       m_clk  [2];
    logic [3:0] m_mode [2];
    logic       m_wq   [2];
    logic       m_rq   [2];
    logic [3:0] m_ptr  [2];

    always #10 clk = ~clk;

    sio_snoop #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .data_cyc(data_cyc), .data_chan(data_chan), .ctl_wq(ctl_wq), .ctl_rq(ctl_rq),
        .card_wait_en(card_wait_en), .card_rdy(card_rdy), .clk_drv(clk_drv),
        .frm_drv(frm_drv), .line_rdy(line_rdy), .dma_req(dma_req), .bus_ready(bus_ready)
    );

    task automatic model_defaults(input int c);
        m_clk[c] = 1'b0; m_mode[c] = 4'b0001; m_wq[c] = 1'b0; m_rq[c] = 1'b0; m_ptr[c] = 4'd0;
    endtask

    task automatic model_write(input int c, input logic [7:0] d);
        logic [3:0] idx;
        if (m_ptr[c] == 4'd0) begin
            m_ptr[c] = d[3:0];
        end else begin
            idx = m_ptr[c];
            m_ptr[c] = 4'd0;
            case (idx)
                4'd1:  m_wq[c] = d[6];
                4'd4:  m_mode[c] = d[5:2];
                4'd9:  begin
                    if (d[6]) begin model_defaults(0); model_defaults(1); end
                    else if (d[7]) model_defaults(c);
                end
                4'd11: m_clk[c] = d[2];
                4'd14: m_rq[c] = d[2];
                default: ;
            endcase
        end
    endtask

    task automatic do_wr(input int c, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = c[0:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(c, d);
    endtask

    function automatic logic [8:0] expect_now();
        logic [1:0] e_clk, e_frm, e_line, e_dma;
        logic       stretch;
        logic       is_in;
        stretch = 1'b0;
        for (int i = 0; i < 2; i++) begin
            e_clk[i] = m_clk[i];
            is_in = (m_mode[i][1:0] != 2'b00) || (m_mode[i][3:2] == 2'b11);
            e_frm[i] = ~is_in;
            e_dma[i] = (m_wq[i] & ctl_wq[i]) | (m_rq[i] & ctl_rq[i]);
            e_line[i] = m_rq[i] ? card_rdy[i] : ctl_rq[i];
            if (!m_wq[i] && card_wait_en && data_cyc && (data_chan == i[0:0]) && ctl_wq[i])
                stretch = 1'b1;
        end
        return {e_clk, e_frm, e_line, e_dma, ~stretch};
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs {clk,frm,line,dma,rdy} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive all 32 pin combinations on each channel and compare every output
    task automatic check_all(input string tag);
        for (int k = 0; k < 64; k++) begin
            if (k % 8 == 0) @(negedge clk);
            ctl_wq = '0; ctl_rq = '0; card_rdy = '0;
            ctl_wq[k[5]]   = k[0];
            ctl_rq[k[5]]   = k[1];
            card_rdy[k[5]] = k[2];
            card_wait_en   = k[3];
            data_cyc       = k[4];
            data_chan      = k[5:5];
            #0.5;
            chk(tag, {clk_drv, frm_drv, line_rdy, dma_req, bus_ready}, expect_now());
            #0.5;
        end
    endtask

    function automatic string tag_of(input int r);
        case (r)
            1:  return "R5";
            4:  return "R4";
            9:  return "R9";
            11: return "R3";
            14: return "R7";
            default: return "R10";
        endcase
    endfunction

    initial begin
        model_defaults(0); model_defaults(1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2: index 0 keeps the pointer idle; upper bits of a pointer load ignored
        do_wr(0, 8'h00);
        do_wr(0, 8'hAB);
        do_wr(0, 8'h04);
        check_all("R2");

        // R11: not visible before the capturing edge, visible after it
        do_wr(1, 8'h0B);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 1'b1; wr_data = 8'h04;
        #1 chk("R11", {7'b0, clk_drv}, {7'b0, 2'b01});
        @(negedge clk);
        wr_en = 1'b0;
        model_write(1, 8'h04);
        #1 chk("R11", {7'b0, clk_drv}, {7'b0, 2'b11});

        // R8: sync-output mode on channel 1 leaves channel 0 untouched
        do_wr(1, 8'h04);
        do_wr(1, 8'h00);
        check_all("R8");

        // R6: stretch request aimed at the other channel does not stall
        @(negedge clk);
        ctl_wq = 2'b01; card_wait_en = 1'b1; data_cyc = 1'b1; data_chan = 1'b1;
        #1 chk("R6", {8'b0, bus_ready}, 9'b1);
        data_chan = 1'b0;
        #1 chk("R6", {8'b0, bus_ready}, 9'b0);

        // exhaustive register/value sweep on both channels
        for (int c = 0; c < 2; c++) begin
            for (int r = 1; r < 16; r++) begin
                for (int v = 0; v < 256; v++) begin
                    do_wr(c, {v[7:4], r[3:0]});
                    do_wr(c, v[7:0]);
                    check_all(tag_of(r));
                end
            end
        end

        // R1: hardware reset in mid-run restores defaults on both channels
        do_wr(0, 8'h0B); do_wr(0, 8'h04);
        do_wr(1, 8'h01); do_wr(1, 8'h40);
        do_wr(1, 8'h0E); do_wr(1, 8'h04);
        do_wr(0, 8'h05);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_defaults(0); model_defaults(1);
        check_all("R1");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule